// File: doc/BRIEF.md
# OTP fuse array controller

This block sits on a simple register bus and fronts a one-time-programmable fuse array organised as 32-bit words. Software sets up a word address, a bit position, a data bit, a redundancy select and several enable and test/trim controls. It then strobes the write-enable register to burn a single bit. Reading the data-out register returns the fuse word at the current address. The word is returned only when the chip-enable, strobe-enable and trim-enable controls are all active. Otherwise a fixed pattern comes back.

Every fuse bit carries a written flag. A bit can be programmed once. A second attempt on the same bit is refused, leaves the array alone and sets a sticky write-once error. At reset the array reads as all ones, except for two words. A configurable serial number is placed at a fixed word index, and its bitwise complement is placed at the following index.

Accesses are 32 bits wide at byte offsets that are multiples of four. The array depth is a parameter. The full-size part uses 4096 words, and a small array suits simulation.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: The sixteen registers sit at byte offsets 0x00 to 0x3C in this order: address, bit index, redundancy select, chip enable, clock, data in, data out, strobe, program, test control, test mode, test repeat, test read, trim, write enable, status. Every register other than data out, status, address and write enable reads back exactly the last value written to it, and reads 0 after reset.
- R2: A read of data out (0x18) returns the fuse word at the stored address when bit 0 of chip enable, bit 0 of strobe and bit 0 of trim are all 1. Otherwise it returns 0x000000FF.
- R3: A write to the address register stores the written value ANDed with DEPTH-1.
- R4: A write to write enable stores only bit 0. When that bit is 1, the redundancy select register is zero and the target bit has not been written, bit (bit index mod 32) of the addressed word takes bit 0 of data in. That bit is then marked as written.
- R5: While the redundancy select register is non-zero, a write-enable write changes no fuse bit and raises no error.
- R6: A program attempt on a bit already marked written leaves the fuse word unchanged and sets the sticky status bit 0 (also driven on `once_err`). Writing status with bit 0 set clears it.
- R7: Writes to data out change no register and no fuse bit.
- R8: After reset, every fuse word outside the serial pair reads 0xFFFFFFFF, all written flags are clear and all registers read 0.
- R9: After reset, word SERIAL_WORD holds SERIAL and word SERIAL_WORD+1 holds its bitwise complement. These bits remain programmable once each.
- R10: Offsets at or above 0x40, or with bits [1:0] non-zero, read 0. A write to such an offset changes nothing except the sticky status bit 1 (also driven on `bad_access`). Writing status with bit 1 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| once_err | output | 1 | Sticky write-once violation flag |
| bad_access | output | 1 | Sticky unmapped-access flag |

## Verification
The hardest situation to reach is a second program attempt on a bit that was already burned. It must hit the same word and the same bit index, with redundancy select back at zero. In between, other addresses, data values and enables may have been changed. The stimulus reaches it by first burning and re-burning one bit in a fixed order. It then runs a long random phase that draws the address from a handful of words and the bit index from four values. That keeps collisions frequent. Meanwhile a behavioural model of the array, its written map and both sticky flags is compared against the outputs every clock.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    localparam int DW       = 32;
    localparam int OFF_W    = 8;
    localparam int BIT_IW   = $clog2(DW);
    localparam int NUM_REGS = 16;
    localparam logic [DW-1:0] GATED_READ = 32'h0000_00FF;

    typedef enum logic [3:0] {
        REG_ADDR = 4'd0,
        REG_BIT  = 4'd1,
        REG_RED  = 4'd2,
        REG_CE   = 4'd3,
        REG_CLK  = 4'd4,
        REG_DIN  = 4'd5,
        REG_DOUT = 4'd6,
        REG_STB  = 4'd7,
        REG_PROG = 4'd8,
        REG_TC   = 4'd9,
        REG_TM   = 4'd10,
        REG_TMR  = 4'd11,
        REG_TR   = 4'd12,
        REG_TRIM = 4'd13,
        REG_WE   = 4'd14,
        REG_STAT = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic     ok;
        reg_idx_e idx;
    } reg_sel_t;

    typedef struct packed {
        logic              valid;
        logic [BIT_IW-1:0] bit_idx;
        logic              value;
    } prog_req_t;

    typedef logic [NUM_REGS-1:0][DW-1:0] reg_file_t;

    // Word-aligned offsets below NUM_REGS*4 are mapped.
    function automatic reg_sel_t decode_off(input logic [OFF_W-1:0] off);
        reg_sel_t s;
        s.ok  = (off[1:0] == 2'b00) && (off[OFF_W-1:6] == '0);
        s.idx = reg_idx_e'(off[5:2]);
        return s;
    endfunction

    // Unprogrammed content of a word.
    function automatic logic [DW-1:0] blank_word(input int unsigned idx,
                                                 input int unsigned ser_idx,
                                                 input logic [DW-1:0] ser);
        if (idx == ser_idx)          return ser;
        else if (idx == ser_idx + 1) return ~ser;
        else                         return '1;
    endfunction

endpackage

// File: rtl/otp_fuse_regs.sv
module otp_fuse_regs
    import otp_fuse_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    input  logic             reject,
    output reg_file_t        regs_q,
    output prog_req_t        prog,
    output logic             once_err_q,
    output logic             bad_q
);
    localparam logic [DW-1:0] ADDR_MASK = DW'(DEPTH - 1);

    reg_sel_t sel;
    logic     we_hit;
    logic     stat_hit;

    assign sel      = decode_off(off);
    assign we_hit   = wr && sel.ok && (sel.idx == REG_WE);
    assign stat_hit = wr && sel.ok && (sel.idx == REG_STAT);

    always_comb begin
        prog.valid   = we_hit && wdata[0] && (regs_q[REG_RED] == '0);
        prog.bit_idx = regs_q[REG_BIT][BIT_IW-1:0];
        prog.value   = regs_q[REG_DIN][0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q     <= '0;
            once_err_q <= 1'b0;
            bad_q      <= 1'b0;
        end else begin
            if (reject) once_err_q <= 1'b1;
            if (wr) begin
                if (!sel.ok) begin
                    bad_q <= 1'b1;
                end else begin
                    case (sel.idx)
                        REG_ADDR: regs_q[REG_ADDR] <= wdata & ADDR_MASK;
                        REG_WE:   regs_q[REG_WE]   <= {{(DW-1){1'b0}}, wdata[0]};
                        REG_DOUT: ;
                        REG_STAT: begin
                            if (wdata[0]) once_err_q <= 1'b0;
                            if (wdata[1]) bad_q      <= 1'b0;
                        end
                        default:  regs_q[sel.idx] <= wdata;
                    endcase
                end
            end
        end
    end

    assert_once_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (once_err_q && !(stat_hit && wdata[0])) |=> once_err_q);

    assert_bad_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (bad_q && !(stat_hit && wdata[1])) |=> bad_q);

endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank
    import otp_fuse_pkg::*;
#(
    parameter int          DEPTH       = 256,
    parameter int          SERIAL_WORD = 252,
    parameter logic [31:0] SERIAL      = 32'h0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  prog_req_t                prog,
    output logic                     reject,
    output logic [DW-1:0]            word
);
    logic [DW-1:0] flag_q [DEPTH];
    logic [DW-1:0] val_q  [DEPTH];
    logic          tgt_written;
    logic          do_prog;
    logic [DW-1:0] base;

    assign tgt_written = flag_q[addr][prog.bit_idx];
    assign do_prog     = prog.valid && !tgt_written;
    assign reject      = prog.valid && tgt_written;

    assign base = blank_word(int'(addr), SERIAL_WORD, SERIAL);
    assign word = (flag_q[addr] & val_q[addr]) | (~flag_q[addr] & base);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) flag_q[i] <= '0;
        end else if (do_prog) begin
            flag_q[addr][prog.bit_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && do_prog) val_q[addr][prog.bit_idx] <= prog.value;
    end

    assert_prog_sets_bit_R4: assert property (@(posedge clk) disable iff (rst)
        do_prog |=> (word[$past(prog.bit_idx)] == $past(prog.value)));

    assert_reject_holds_word_R6: assert property (@(posedge clk) disable iff (rst)
        reject |=> $stable(word));

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int          DEPTH       = 256,
    parameter int          SERIAL_WORD = 252,
    parameter logic [31:0] SERIAL      = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        once_err,
    output logic        bad_access
);
    localparam int AW = $clog2(DEPTH);

    reg_file_t     regs_q;
    prog_req_t     prog;
    logic          reject;
    logic [DW-1:0] fuse_word;
    logic          rd_open;
    reg_sel_t      sel;

    otp_fuse_regs #(.DEPTH(DEPTH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .off        (reg_addr),
        .wdata      (reg_wdata),
        .reject     (reject),
        .regs_q     (regs_q),
        .prog       (prog),
        .once_err_q (once_err),
        .bad_q      (bad_access)
    );

    otp_fuse_bank #(
        .DEPTH       (DEPTH),
        .SERIAL_WORD (SERIAL_WORD),
        .SERIAL      (SERIAL)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .addr   (regs_q[REG_ADDR][AW-1:0]),
        .prog   (prog),
        .reject (reject),
        .word   (fuse_word)
    );

    assign sel     = decode_off(reg_addr);
    assign rd_open = regs_q[REG_CE][0] && regs_q[REG_STB][0] && regs_q[REG_TRIM][0];

    always_comb begin
        if (!sel.ok) begin
            reg_rdata = '0;
        end else begin
            case (sel.idx)
                REG_DOUT: reg_rdata = rd_open ? fuse_word : GATED_READ;
                REG_STAT: reg_rdata = {{(DW-2){1'b0}}, bad_access, once_err};
                default:  reg_rdata = regs_q[sel.idx];
            endcase
        end
    end

    assert_dout_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel.ok && (sel.idx == REG_DOUT)) |=> ($stable(regs_q) && $stable(fuse_word)));

    assert_red_blocks_prog_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel.ok && (sel.idx == REG_WE) && (regs_q[REG_RED] != '0))
        |=> ($stable(fuse_word) && !($rose(once_err))));

endmodule

// File: tb/otp_fuse_ctrl_tb.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb;
    localparam int          DEPTH = 64;
    localparam int          SW    = 62;
    localparam logic [31:0] SER   = 32'hA5C3_1E07;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        once_err;
    logic        bad_access;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    otp_fuse_ctrl #(.DEPTH(DEPTH), .SERIAL_WORD(SW), .SERIAL(SER)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .once_err(once_err), .bad_access(bad_access)
    );

    // Behavioural reference model
    logic [31:0] m_fuse [DEPTH];
    logic [31:0] m_flag [DEPTH];
    logic [31:0] m_reg  [16];
    bit          m_oerr, m_bad;

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_fuse[i] = (i == SW) ? SER : (i == SW + 1) ? ~SER : 32'hFFFF_FFFF;
            m_flag[i] = 32'h0;
        end
        for (int i = 0; i < 16; i++) m_reg[i] = 32'h0;
        m_oerr = 1'b0;
        m_bad  = 1'b0;
    endtask

    function automatic bit mapped(logic [7:0] a);
        return (a[1:0] == 2'b00) && (a < 8'h40);
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        int k = int'(a[5:2]);
        if (!mapped(a)) return 32'h0;
        if (k == 6) begin
            if (m_reg[3][0] && m_reg[7][0] && m_reg[13][0]) return m_fuse[m_reg[0]];
            return 32'h0000_00FF;
        end
        if (k == 15) return {30'd0, m_bad, m_oerr};
        return m_reg[k];
    endfunction

    task automatic model_write(logic [7:0] a, logic [31:0] d);
        int k = int'(a[5:2]);
        if (!mapped(a)) begin
            m_bad = 1'b1;
            return;
        end
        case (k)
            0: m_reg[0] = d & (DEPTH - 1);
            6: ;
            14: begin
                m_reg[14] = d & 32'h1;
                if (d[0] && m_reg[2] == 32'h0) begin
                    int w = int'(m_reg[0]);
                    int b = int'(m_reg[1] % 32);
                    if (m_flag[w][b]) m_oerr = 1'b1;
                    else begin
                        m_fuse[w][b] = m_reg[5][0];
                        m_flag[w][b] = 1'b1;
                    end
                end
            end
            15: begin
                if (d[0]) m_oerr = 1'b0;
                if (d[1]) m_bad  = 1'b0;
            end
            default: m_reg[k] = d;
        endcase
    endtask

    function automatic string tag_of(logic [7:0] a);
        if (!mapped(a))   return "R10";
        if (a == 8'h00)   return "R3";
        if (a == 8'h18)   return "R2";
        if (a == 8'h38)   return "R4";
        if (a == 8'h3C)   return "R6";
        return "R1";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (offset %h)", tag, act, exp, reg_addr);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
            check("R6", {31'd0, once_err}, {31'd0, m_oerr});
            check("R10", {31'd0, bad_access}, {31'd0, m_bad});
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        model_write(a, d);
        reg_wr = 1'b0;
    endtask

    task automatic rd_exp(logic [7:0] a, string tag, logic [31:0] exp);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        check(tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1: actual=watchdog-expired expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R8 reset state
        rd_exp(8'h00, "R8", 32'h0);
        rd_exp(8'h3C, "R8", 32'h0);
        rd_exp(8'h18, "R8", 32'h0000_00FF);
        rd_exp(8'h34, "R8", 32'h0);

        // R1 plain readback
        wr(8'h24, 32'hDEAD_BEEF);
        rd_exp(8'h24, "R1", 32'hDEAD_BEEF);
        wr(8'h10, 32'h1234_5678);
        rd_exp(8'h10, "R1", 32'h1234_5678);

        // R2 read gating
        wr(8'h0C, 32'h1);
        rd_exp(8'h18, "R2", 32'h0000_00FF);
        wr(8'h1C, 32'h3);
        rd_exp(8'h18, "R2", 32'h0000_00FF);
        wr(8'h34, 32'h8000_0001);
        rd_exp(8'h18, "R2", 32'hFFFF_FFFF);
        rd_exp(8'h1C, "R1", 32'h3);

        // R3 address masking
        wr(8'h00, 32'hFFFF_FFC5);
        rd_exp(8'h00, "R3", 32'h0000_0005);
        rd_exp(8'h18, "R8", 32'hFFFF_FFFF);

        // R9 serial pair
        wr(8'h00, SW);
        rd_exp(8'h18, "R9", SER);
        wr(8'h00, SW + 1);
        rd_exp(8'h18, "R9", ~SER);

        // R4 program one bit
        wr(8'h00, 32'd5);
        wr(8'h04, 32'd3);
        wr(8'h14, 32'd0);
        wr(8'h38, 32'd1);
        rd_exp(8'h18, "R4", 32'hFFFF_FFF7);
        rd_exp(8'h38, "R4", 32'h1);

        // R6 second attempt on the same bit
        wr(8'h14, 32'd1);
        wr(8'h38, 32'd1);
        rd_exp(8'h18, "R6", 32'hFFFF_FFF7);
        rd_exp(8'h3C, "R6", 32'h1);
        wr(8'h3C, 32'h1);
        rd_exp(8'h3C, "R6", 32'h0);

        // R5 redundancy select blocks programming
        wr(8'h08, 32'h1);
        wr(8'h04, 32'd4);
        wr(8'h14, 32'd0);
        wr(8'h38, 32'd1);
        rd_exp(8'h18, "R5", 32'hFFFF_FFF7);
        rd_exp(8'h3C, "R5", 32'h0);
        wr(8'h08, 32'h0);

        // R4 enable bit clear: stored as 0, no programming
        wr(8'h38, 32'h2);
        rd_exp(8'h38, "R4", 32'h0);
        rd_exp(8'h18, "R4", 32'hFFFF_FFF7);

        // R4 bit index wraps modulo 32
        wr(8'h04, 32'd39);
        wr(8'h38, 32'd1);
        rd_exp(8'h18, "R4", 32'hFFFF_FF77);

        // R7 data-out writes ignored
        wr(8'h18, 32'h0);
        rd_exp(8'h18, "R7", 32'hFFFF_FF77);
        rd_exp(8'h3C, "R7", 32'h0);

        // R10 unmapped and misaligned
        wr(8'h44, 32'h5);
        rd_exp(8'h3C, "R10", 32'h2);
        rd_exp(8'h05, "R10", 32'h0);
        rd_exp(8'h80, "R10", 32'h0);
        wr(8'h3C, 32'h2);
        rd_exp(8'h3C, "R10", 32'h0);

        // R9 serial bit still programmable once
        wr(8'h00, SW);
        wr(8'h04, 32'd0);
        wr(8'h14, 32'd0);
        wr(8'h38, 32'd1);
        rd_exp(8'h18, "R9", SER & 32'hFFFF_FFFE);

        // Random phase with frequent collisions
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom_range(9, 0);
            case (sel)
                0: wr(8'h00, $urandom_range(7, 0));
                1: wr(8'h04, $urandom_range(3, 0));
                2: wr(8'h14, $urandom);
                3, 4, 5: wr(8'h38, $urandom_range(3, 0));
                6: wr(8'h08, ($urandom_range(3, 0) == 0) ? 32'h1 : 32'h0);
                7: wr(8'h3C, $urandom_range(3, 0));
                8: wr(8'h0C + 8'(4 * $urandom_range(1, 0)), $urandom_range(1, 0) | 32'h0);
                default: wr(8'($urandom_range(255, 0)), $urandom);
            endcase
            rd_exp(8'h18, "R2", model_read(8'h18));
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule